// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits beside the decode stage of a small 8-bit processor core. It decides when the core has to leave its instruction stream for an interrupt, and it supplies the 16-bit address to jump to. There are two request sources. The first is a maskable request line that is gated by an enable bit. Decode sets that bit with one strobe and clears it with another. The second is a non-maskable request that no enable bit can block.

Requests are looked at only at a sample point. A sample point is an instruction boundary reported by the core, or any cycle in which the core is halted. On a take, the block does three things one cycle later. It pulses a take strobe together with a push request, which asks the return stack to save the full core state. It presents the vector of the winning source. If the core was halted, it also raises a wake strobe. The vector for each source is held in a register that can be written from outside.

Two behaviours need care. A maskable request that is seen while the enable is clear is thrown away for good, and it only counts again after the line has gone low. The core is released from halt only through a taken interrupt.

Top module: `intr_sequencer`

## Requirements
- R1: After reset, take_o, push_o and wake_o are 0, vector_o is 16'h0000 and ien_o is 0. The maskable vector resets to 16'hFFFE and the non-maskable vector resets to 16'hFFFA.
- R2: One cycle after en_set_i, ien_o reads 1. One cycle after en_clr_i, ien_o reads 0. If both strobes come in the same cycle, the clear wins.
- R3: At a sample point, if irq_i is high, ien_o is 1 and the request is not blocked, the maskable source is taken. On the next cycle take_o and push_o are 1 for one cycle and vector_o shows the maskable vector.
- R4: If irq_i is high in any cycle while ien_o is 0, that request is blocked. It is never taken, even after interrupts are enabled again, until irq_i has been low for at least one cycle.
- R5: A rising edge on nmi_i is remembered until the next sample point and is then taken exactly once, whatever ien_o is. Holding nmi_i high does not cause a second take. vector_o shows the non-maskable vector.
- R6: When a non-maskable interrupt is pending at the same sample point as a valid maskable request, the non-maskable source wins. The maskable request is then blocked under R4.
- R7: Every take sets ien_o to 0 on the next cycle. restore_i loads ien_o from restore_ien_i. A take in the same cycle overrides restore_i, and restore_i overrides the strobes.
- R8: While halted_i is 1, every cycle is a sample point. A take made in a halted cycle asserts wake_o together with take_o.
- R9: When vec_we_i is 1, vec_wdata_i is written into the vector chosen by vec_sel_i (0 = maskable, 1 = non-maskable). Any take in a later cycle uses the new value.
- R10: When neither boundary_i nor halted_i is 1, nothing is taken. vector_o keeps its last value between takes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | 1 | Maskable request, level |
| nmi_i | input | 1 | Non-maskable request, edge-detected |
| en_set_i | input | 1 | Strobe from decode: enable the maskable source |
| en_clr_i | input | 1 | Strobe from decode: disable the maskable source |
| restore_i | input | 1 | Saved state popped from the return stack |
| restore_ien_i | input | 1 | Enable bit inside the popped state |
| halted_i | input | 1 | Core is halted |
| boundary_i | input | 1 | Instruction boundary strobe |
| vec_we_i | input | 1 | Vector register write enable |
| vec_sel_i | input | 1 | Vector select: 0 maskable, 1 non-maskable |
| vec_wdata_i | input | 16 | Vector write data |
| take_o | output | 1 | One-cycle strobe: interrupt taken |
| push_o | output | 1 | Request to push the core state onto the return stack |
| vector_o | output | 16 | Jump address of the source that was taken |
| wake_o | output | 1 | Clears the core's halt state |
| ien_o | output | 1 | Current maskable enable, which is saved with the core state |

## Verification
The hardest situation to reach is a blocked maskable request meeting a re-enable. The line has to stay high across a stretch where the enable is off. The enable must then come back through a strobe or a restore while the line is still high. The stimulus produces this in two ways. In the first, the request is raised with the enable clear, then the enable is set and boundaries are pulsed; the line is dropped and raised again only afterwards. In the second, a non-maskable edge is made to coincide with a live maskable request, so the mask that the take applies blocks the maskable line. Every cycle is compared against a behavioural model.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int unsigned NUM_SRC = 2;
  typedef enum logic {
    SRC_MASK = 1'b0,
    SRC_NMI  = 1'b1
  } src_e;
endpackage

// File: rtl/intr_nmi_edge.sv
module intr_nmi_edge (
  input  logic clk,
  input  logic rst,
  input  logic nmi_i,
  input  logic sample_i,
  output logic avail_o,
  output logic take_o
);
  logic prev_q;
  logic pend_q;
  logic edge_w;

  // A rising edge counts as available in the cycle it is seen.
  assign edge_w  = nmi_i & ~prev_q;
  assign avail_o = pend_q | edge_w;
  assign take_o  = sample_i & avail_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= nmi_i;
      pend_q <= avail_o & ~take_o;
    end
  end
endmodule

// File: rtl/intr_mask_gate.sv
module intr_mask_gate (
  input  logic clk,
  input  logic rst,
  input  logic irq_i,
  input  logic sample_i,
  input  logic nmi_win_i,
  input  logic nmi_take_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic restore_i,
  input  logic restore_ien_i,
  output logic take_o,
  output logic ien_o
);
  logic ien_q;
  logic block_q;
  logic ien_d;

  assign take_o = sample_i & ~nmi_win_i & irq_i & ien_q & ~block_q;
  assign ien_o  = ien_q;

  // Update order: a take beats a restore, a restore beats the strobes,
  // and a clear beats a set.
  always_comb begin
    ien_d = ien_q;
    if (nmi_take_i | take_o) ien_d = 1'b0;
    else if (restore_i)      ien_d = restore_ien_i;
    else if (clr_i)          ien_d = 1'b0;
    else if (set_i)          ien_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q   <= 1'b0;
      block_q <= 1'b0;
    end else begin
      ien_q   <= ien_d;
      // A request seen while masked stays spent until the line goes low.
      block_q <= irq_i & (block_q | ~ien_q);
    end
  end
endmodule

// File: rtl/intr_vec_regs.sv
module intr_vec_regs #(
  parameter int unsigned       AW      = 16,
  parameter logic [AW-1:0]     RST_MSK = 16'hFFFE,
  parameter logic [AW-1:0]     RST_NMI = 16'hFFFA
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_i,
  input  logic          sel_i,
  input  logic [AW-1:0] wdata_i,
  output logic [AW-1:0] vec_msk_o,
  output logic [AW-1:0] vec_nmi_o
);
  import intr_pkg::*;

  logic [AW-1:0] vec_q [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_vec
    localparam logic [AW-1:0] RV = (g == int'(SRC_NMI)) ? RST_NMI : RST_MSK;
    always_ff @(posedge clk) begin
      if (rst)                              vec_q[g] <= RV;
      else if (we_i && (int'(sel_i) == g))  vec_q[g] <= wdata_i;
    end
  end

  assign vec_msk_o = vec_q[int'(SRC_MASK)];
  assign vec_nmi_o = vec_q[int'(SRC_NMI)];
endmodule

// File: rtl/intr_sequencer.sv
module intr_sequencer #(
  parameter int unsigned   AW      = 16,
  parameter logic [AW-1:0] RST_MSK = 16'hFFFE,
  parameter logic [AW-1:0] RST_NMI = 16'hFFFA
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          irq_i,
  input  logic          nmi_i,
  input  logic          en_set_i,
  input  logic          en_clr_i,
  input  logic          restore_i,
  input  logic          restore_ien_i,
  input  logic          halted_i,
  input  logic          boundary_i,
  input  logic          vec_we_i,
  input  logic          vec_sel_i,
  input  logic [AW-1:0] vec_wdata_i,
  output logic          take_o,
  output logic          push_o,
  output logic [AW-1:0] vector_o,
  output logic          wake_o,
  output logic          ien_o
);
  logic          sample;
  logic          nmi_avail;
  logic          take_nmi;
  logic          take_irq;
  logic          take_any;
  logic [AW-1:0] vec_msk;
  logic [AW-1:0] vec_nmi;

  assign sample   = boundary_i | halted_i;
  assign take_any = take_nmi | take_irq;

  intr_nmi_edge u_nmi (
    .clk      (clk),
    .rst      (rst),
    .nmi_i    (nmi_i),
    .sample_i (sample),
    .avail_o  (nmi_avail),
    .take_o   (take_nmi)
  );

  intr_mask_gate u_mask (
    .clk           (clk),
    .rst           (rst),
    .irq_i         (irq_i),
    .sample_i      (sample),
    .nmi_win_i     (nmi_avail),
    .nmi_take_i    (take_nmi),
    .set_i         (en_set_i),
    .clr_i         (en_clr_i),
    .restore_i     (restore_i),
    .restore_ien_i (restore_ien_i),
    .take_o        (take_irq),
    .ien_o         (ien_o)
  );

  intr_vec_regs #(.AW(AW), .RST_MSK(RST_MSK), .RST_NMI(RST_NMI)) u_vec (
    .clk       (clk),
    .rst       (rst),
    .we_i      (vec_we_i),
    .sel_i     (vec_sel_i),
    .wdata_i   (vec_wdata_i),
    .vec_msk_o (vec_msk),
    .vec_nmi_o (vec_nmi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take_o   <= 1'b0;
      push_o   <= 1'b0;
      wake_o   <= 1'b0;
      vector_o <= '0;
    end else begin
      take_o <= take_any;
      push_o <= take_any;
      wake_o <= take_any & halted_i;
      if (take_nmi)      vector_o <= vec_nmi;
      else if (take_irq) vector_o <= vec_msk;
    end
  end
endmodule

// File: rtl/intr_seq_chk.sv
module intr_seq_chk (
  input logic clk,
  input logic rst,
  input logic boundary_i,
  input logic halted_i,
  input logic take_irq,
  input logic take_nmi,
  input logic nmi_avail,
  input logic ien_o,
  input logic take_o,
  input logic wake_o
);
  // R3
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    take_irq |-> ien_o);
  // R6
  nmi_first_chk: assert property (@(posedge clk) disable iff (rst)
    take_irq |-> !nmi_avail);
  // R10
  sample_only_chk: assert property (@(posedge clk) disable iff (rst)
    (take_irq || take_nmi) |-> (boundary_i || halted_i));
  // R7
  take_masks_chk: assert property (@(posedge clk) disable iff (rst)
    take_o |-> !ien_o);
  // R8
  wake_with_take_chk: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> take_o);
  // R8
  wake_halted_chk: assert property (@(posedge clk) disable iff (rst)
    (take_nmi && halted_i) |=> wake_o);
endmodule

bind intr_sequencer intr_seq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .boundary_i (boundary_i),
  .halted_i   (halted_i),
  .take_irq   (take_irq),
  .take_nmi   (take_nmi),
  .nmi_avail  (nmi_avail),
  .ien_o      (ien_o),
  .take_o     (take_o),
  .wake_o     (wake_o)
);

// File: tb/intr_sequencer_test.sv
module intr_sequencer_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic irq = 0, nmi = 0, eset = 0, eclr = 0, rest = 0, rien = 0;
  logic halted = 0, bnd = 0, vwe = 0, vsel = 0;
  logic [15:0] vwd = '0;
  logic take, push, wake, ien;
  logic [15:0] vec;

  int total = 0, bad = 0, cycles = 0, takes = 0;
  string phase = "R1";
  bit done = 0;

  // model state
  bit m_ien, m_blk, m_prev, m_pend, m_take, m_wake;
  logic [15:0] m_vmsk, m_vnmi, m_vec;

  always #2 clk = ~clk;

  intr_sequencer uut (
    .clk(clk), .rst(rst), .irq_i(irq), .nmi_i(nmi), .en_set_i(eset),
    .en_clr_i(eclr), .restore_i(rest), .restore_ien_i(rien),
    .halted_i(halted), .boundary_i(bnd), .vec_we_i(vwe), .vec_sel_i(vsel),
    .vec_wdata_i(vwd), .take_o(take), .push_o(push), .vector_o(vec),
    .wake_o(wake), .ien_o(ien)
  );

  always @(posedge clk) begin
    bit s, avail, tn, tm;
    if (rst) begin
      m_ien = 0; m_blk = 0; m_prev = 0; m_pend = 0; m_take = 0; m_wake = 0;
      m_vmsk = 16'hFFFE; m_vnmi = 16'hFFFA; m_vec = 16'h0000;
    end else begin
      s = bnd || halted;
      avail = m_pend || (nmi && !m_prev);
      tn = s && avail;
      tm = s && !avail && irq && m_ien && !m_blk;
      m_take = tn || tm;
      m_wake = m_take && halted;
      if (tn) m_vec = m_vnmi;
      else if (tm) m_vec = m_vmsk;
      m_pend = avail && !tn;
      m_prev = nmi;
      m_blk = irq && (m_blk || !m_ien);
      if (m_take) m_ien = 0;
      else if (rest) m_ien = rien;
      else if (eclr) m_ien = 0;
      else if (eset) m_ien = 1;
      if (vwe) begin
        if (vsel) m_vnmi = vwd; else m_vmsk = vwd;
      end
    end
  end

  task automatic chk(input bit ok, input string what, input string act, input string exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%s expected=%s", phase, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(take === m_take, "take_o", $sformatf("%b", take), $sformatf("%b", m_take));
      chk(push === m_take, "push_o", $sformatf("%b", push), $sformatf("%b", m_take));
      chk(wake === m_wake, "wake_o", $sformatf("%b", wake), $sformatf("%b", m_wake));
      chk(ien === m_ien, "ien_o", $sformatf("%b", ien), $sformatf("%b", m_ien));
      chk(vec === m_vec, "vector_o", $sformatf("%h", vec), $sformatf("%h", m_vec));
      if (take === 1'b1) takes++;
    end
  end

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected<=20000", cycles);
      finish_up();
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one-cycle strobe helpers
  task automatic pulse_bnd();
    bnd = 1; step(1); bnd = 0;
  endtask

  initial begin
    step(3); rst = 0;
    // R1 reset state
    phase = "R1";
    chk(take === 0 && push === 0 && wake === 0, "strobes", $sformatf("%b%b%b", take, push, wake), "000");
    chk(vec === 16'h0000, "vector", $sformatf("%h", vec), "0000");
    chk(ien === 0, "enable", $sformatf("%b", ien), "0");
    step(2);

    // R5 default non-maskable vector, edge taken once despite mask
    phase = "R5";
    takes = 0;
    nmi = 1; step(3);
    pulse_bnd(); step(1);
    chk(vec === 16'hFFFA, "R1 nmi default vector", $sformatf("%h", vec), "fffa");
    for (int i = 0; i < 4; i++) begin pulse_bnd(); step(1); end
    step(1);
    chk(takes == 1, "single take on held nmi", $sformatf("%0d", takes), "1");
    nmi = 0; step(2);

    // R2 strobes
    phase = "R2";
    eset = 1; step(1); eset = 0; step(1);
    chk(ien === 1, "set", $sformatf("%b", ien), "1");
    eclr = 1; step(1); eclr = 0; step(1);
    chk(ien === 0, "clear", $sformatf("%b", ien), "0");
    eset = 1; eclr = 1; step(1); eset = 0; eclr = 0; step(1);
    chk(ien === 0, "clear wins", $sformatf("%b", ien), "0");

    // R10 no boundary means no take
    phase = "R10";
    eset = 1; step(1); eset = 0;
    takes = 0; irq = 1; step(6);
    chk(takes == 0, "no take without sample point", $sformatf("%0d", takes), "0");

    // R3 maskable taken at boundary
    phase = "R3";
    pulse_bnd(); step(1);
    chk(vec === 16'hFFFE, "maskable vector", $sformatf("%h", vec), "fffe");
    irq = 0; step(2);

    // R4 masked request dropped
    phase = "R4";
    irq = 1; step(1);
    pulse_bnd();
    eset = 1; step(1); eset = 0;
    takes = 0;
    for (int i = 0; i < 5; i++) begin pulse_bnd(); step(1); end
    chk(takes == 0, "blocked after re-enable", $sformatf("%0d", takes), "0");
    irq = 0; step(1); irq = 1;
    pulse_bnd(); step(1);
    chk(takes == 1, "taken after line cycles", $sformatf("%0d", takes), "1");
    irq = 0; step(2);

    // R5 edge remembered until a later sample point
    phase = "R5";
    nmi = 1; step(1); nmi = 0; takes = 0; step(4);
    chk(takes == 0, "pending waits", $sformatf("%0d", takes), "0");
    pulse_bnd(); step(1);
    chk(takes == 1, "pending taken", $sformatf("%0d", takes), "1");

    // R6 priority
    phase = "R6";
    eset = 1; step(1); eset = 0;
    irq = 1; nmi = 1; bnd = 1; step(1); bnd = 0;
    chk(vec === 16'hFFFA, "nmi wins", $sformatf("%h", vec), "fffa");
    eset = 1; step(1); eset = 0; takes = 0;
    pulse_bnd(); step(1);
    chk(takes == 0, "loser blocked", $sformatf("%0d", takes), "0");
    irq = 0; nmi = 0; step(2);

    // R7 restore and take precedence
    phase = "R7";
    rest = 1; rien = 1; step(1); rest = 0; step(1);
    chk(ien === 1, "restore loads", $sformatf("%b", ien), "1");
    rest = 1; rien = 0; eset = 1; step(1); rest = 0; eset = 0; step(1);
    chk(ien === 0, "restore beats set", $sformatf("%b", ien), "0");
    nmi = 1; bnd = 1; rest = 1; rien = 1; step(1);
    nmi = 0; bnd = 0; rest = 0; step(1);
    chk(ien === 0, "take beats restore", $sformatf("%b", ien), "0");

    // R9 vector writes
    phase = "R9";
    vwe = 1; vsel = 1; vwd = 16'h1234; step(1);
    vsel = 0; vwd = 16'hBEEF; step(1); vwe = 0;
    nmi = 1; pulse_bnd(); nmi = 0; step(1);
    chk(vec === 16'h1234, "new nmi vector", $sformatf("%h", vec), "1234");
    eset = 1; step(1); eset = 0; irq = 1;
    pulse_bnd(); irq = 0; step(1);
    chk(vec === 16'hBEEF, "new maskable vector", $sformatf("%h", vec), "beef");

    // R8 halted: every cycle samples, wake with take
    phase = "R8";
    halted = 1; step(3);
    nmi = 1; step(1); nmi = 0;
    chk(wake === 1 && take === 1, "wake on nmi", $sformatf("%b%b", wake, take), "11");
    step(1);
    eset = 1; step(1); eset = 0; irq = 1; step(1);
    chk(wake === 1, "wake on maskable", $sformatf("%b", wake), "1");
    irq = 0; halted = 0; step(3);

    finish_up();
  end
endmodule